// File: doc/BRIEF.md
# Serial Configuration Port Slave with Register Readback

This block is the control port of a data converter. An external SPI master reaches a small bank of 16-bit configuration registers through it. A transfer is a 24-bit word, sent most significant bit first: 8 address bits, then 16 data bits. The master may send any number of words back to back while chip select stays low. An internal bit counter marks where one word ends and the next begins, and leftover bits that never complete a word are dropped. The serial pins are sampled with the system clock after a two-stage synchronizer, so SCLK must be several times slower than `clk`.

After reset the port is in write mode. Every complete word writes its data bits into the addressed register, and SO stays low. Setting the read-enable flag puts the port in read mode. The flag is bit 0 of register 0x00. In read mode the addressed register comes back on SO during the last 16 bit times of the same word. Writes in read mode are blocked for every register except 0x00, which stays writable so the flag can be cleared again.

A one-cycle `soft_rst` pulse returns every register to zero. The `standby` input is registered onto `power_down`, which powers down the converter core. The serial port keeps working while `standby` is high.

Top module: `spi_cfg_slave`

## Requirements
- R1: A word is 24 bits, sent MSB first: address in bits 23..16, data in bits 15..0. Register i appears on `cfg_flat[16*i +: 16]`. A write takes effect when the 24th bit is captured.
- R2: SI is captured on rising SCLK edges. SO changes only after falling SCLK edges, so it holds steady while SCLK is high.
- R3: Several words may follow one another in one chip-select window. Trailing bits that do not complete a word change no register, and raising CS_n clears the bit counter.
- R4: After reset the port is in write mode. In write mode SO stays low for the whole word.
- R5: While bit 0 of register 0x00 is 1, a word returns the addressed register on SO, MSB first, in its bit times 8 to 23. The value returned is the one held before that word's own write.
- R6: In read mode, writes to any address other than 0x00 are suppressed. Writes to 0x00 still take effect, so writing 0 there returns the port to write mode.
- R7: A one-cycle `soft_rst` pulse sets all registers to zero, which also clears read mode.
- R8: `power_down` equals `standby` delayed by one `clk` cycle. Register writes and reads keep working while `standby` is high.
- R9: SO is low while CS_n is high.
- R10: Writes to addresses at or above NUM_REGS (8) are ignored. Reads from such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | One-cycle pulse that restores register defaults |
| standby | input | 1 | Active-high standby request |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| power_down | output | 1 | Registered copy of standby |
| cfg_flat | output | 128 | All registers, register i at bits 16*i+15..16*i |

## Verification
The embedded assertions check on every cycle that SO is low outside a chip-select window and that the bit counter stays in range and clears with chip select. They also check that registers change only on a completed word or a soft reset, that a soft reset clears them, and that `power_down` tracks `standby`. Only the bench scenarios can show the rest, because that needs a model of the register contents. This covers the value read back in read mode and the suppression rule for writes in read mode. It also covers words packed back to back, dropped trailing bits and out-of-range addresses. The bench mixes seeded random words and windows with directed cases.

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int RDEN_BIT = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_rst,
  input  logic                       standby,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       si,
  output logic                       so,
  output logic                       power_down,
  output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W - 1);

  logic [2:0] sclk_q;
  logic [1:0] cs_q, si_q;
  logic [WORD_W-2:0] shft;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rd_sh;
  logic              rd_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0; cs_q <= '1; si_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      si_q   <= {si_q[0], si};
    end

  wire cs_act    = !cs_q[1];
  wire sclk_rise = cs_act &&  sclk_q[1] && !sclk_q[2];
  wire sclk_fall = cs_act && !sclk_q[1] &&  sclk_q[2];

  wire [WORD_W-1:0] word_in = {shft, si_q[1]};
  wire [ADDR_W-1:0] rd_addr = word_in[ADDR_W-1:0];
  wire [ADDR_W-1:0] wr_addr = word_in[WORD_W-1 -: ADDR_W];
  wire [DATA_W-1:0] wr_data = word_in[DATA_W-1:0];
  wire              rd_en   = regs[0][RDEN_BIT];
  wire rd_ok  = rd_addr < ADDR_W'(NUM_REGS);
  wire wr_ok  = wr_addr < ADDR_W'(NUM_REGS);
  wire wr_evt = sclk_rise && cnt == LAST_BIT && wr_ok && (!rd_en || wr_addr == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shft <= '0; cnt <= '0;
    end else if (!cs_act) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      shft <= word_in[WORD_W-2:0];
      cnt  <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_act <= 1'b0; rd_sh <= '0; so <= 1'b0;
    end else if (!cs_act) begin
      rd_act <= 1'b0; so <= 1'b0;
    end else begin
      if (sclk_rise && cnt == ADDR_END) begin
        rd_act <= rd_en;
        rd_sh  <= rd_ok ? regs[rd_addr[IDX_W-1:0]] : '0;
      end
      if (sclk_rise && cnt == LAST_BIT) rd_act <= 1'b0;
      if (sclk_fall) begin
        so <= rd_act & rd_sh[DATA_W-1];
        if (rd_act) rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_evt) begin
      regs[wr_addr[IDX_W-1:0]] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) power_down <= 1'b0;
    else        power_down <= standby;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfg_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  a_r9_so_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |=> !so);
  a_r3_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[1] |=> cnt == '0);
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_BIT);
  a_r1_write_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_flat) |-> $past(wr_evt || soft_rst));
  a_r7_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> cfg_flat == '0);
  a_r8_pd_follow: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> power_down);
  a_r8_pd_release: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |=> !power_down);
endmodule

// File: tb/test_spi_cfg_slave.sv
module test_spi_cfg_slave;
  logic clk = 0, rst_n = 0, soft_rst = 0, standby = 0;
  logic cs_n = 1, sclk = 0, si = 0;
  logic so, power_down;
  logic [127:0] cfg_flat;

  int checks = 0, errors = 0;
  logic [15:0] model [8];

  always #2.5 clk = ~clk;

  spi_cfg_slave i_spi_cfg_slave (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .standby(standby),
    .cs_n(cs_n), .sclk(sclk), .si(si), .so(so),
    .power_down(power_down), .cfg_flat(cfg_flat));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    return (a < 8) ? model[a[2:0]] : 16'h0;
  endfunction

  function automatic bit rd_mode();
    return model[0][0];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits,
                      output logic [15:0] rd, output bit stab, output bit early0);
    logic b;
    rd = '0; stab = 1; early0 = 1;
    for (int j = 0; j < nbits; j++) begin
      sclk = 0; si = w[23-j];
      tick(8);
      b = so;
      if (j >= 8) rd[15-(j-8)] = b;
      else if (b !== 1'b0) early0 = 0;
      sclk = 1;
      tick(8);
      if (so !== b) stab = 0;
    end
    sclk = 0;
    tick(8);
  endtask

  task automatic cs_open();  cs_n = 0; tick(8); endtask
  task automatic cs_close(); cs_n = 1; tick(8); endtask

  task automatic do_word(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] rd, exp;
    bit stab, early0, rm;
    rm  = rd_mode();
    exp = rm ? exp_read(a) : 16'h0;
    xfer({a, d}, 24, rd, stab, early0);
    if (rm) chk(rd === exp, "R5 readback", {16'h0, rd}, {16'h0, exp});
    else    chk(rd === 16'h0, "R4 SO low in write mode", {16'h0, rd}, 32'h0);
    chk(stab && early0, "R2 SO steady while SCLK high", {31'h0, stab}, 32'h1);
    if (a < 8 && (!model[0][0] || a == 0)) model[a[2:0]] = d;
  endtask

  task automatic check_cfg(input string tag);
    for (int i = 0; i < 8; i++)
      chk(cfg_flat[16*i +: 16] === model[i], tag, {16'h0, cfg_flat[16*i +: 16]}, {16'h0, model[i]});
  endtask

  task automatic single(input logic [7:0] a, input logic [15:0] d);
    cs_open(); do_word(a, d); cs_close();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd; bit stab, e0;
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) model[i] = '0;
    tick(4); rst_n = 1; tick(4);

    chk(so === 1'b0, "R9 SO low after reset", {31'h0, so}, 0);
    chk(power_down === 1'b0, "R8 power_down reset", {31'h0, power_down}, 0);
    check_cfg("R7 registers zero after reset");

    single(8'h03, 16'hA5C3);
    check_cfg("R1 write takes effect");

    cs_open();
    do_word(8'h01, 16'h1234); do_word(8'h02, 16'hBEEF); do_word(8'h07, 16'h8001);
    cs_close();
    check_cfg("R3 three words in one window");

    cs_open();
    do_word(8'h05, 16'h0F0F);
    xfer({8'h02, 16'h5555}, 10, rd, stab, e0);
    cs_close();
    check_cfg("R3 trailing bits ignored");
    single(8'h06, 16'h6666);
    check_cfg("R3 counter cleared by CS");
    chk(so === 1'b0, "R9 SO low with CS high", {31'h0, so}, 0);

    single(8'h09, 16'hFFFF);
    check_cfg("R10 out-of-range write ignored");

    single(8'h00, 16'h0001);
    check_cfg("R6 read-enable set");
    single(8'h03, 16'h1111);
    check_cfg("R6 write suppressed in read mode");
    cs_open(); do_word(8'h02, 16'h0); do_word(8'h0A, 16'h0); do_word(8'h00, 16'h0001); cs_close();
    chk(so === 1'b0, "R9 SO low after read window", {31'h0, so}, 0);
    single(8'h00, 16'h0000);
    check_cfg("R6 read mode cleared via address 0");
    single(8'h03, 16'h2222);
    check_cfg("R4 back in write mode");

    standby = 1; tick(2);
    chk(power_down === 1'b1, "R8 power_down follows standby", {31'h0, power_down}, 1);
    single(8'h04, 16'h4444); single(8'h00, 16'h0001); single(8'h04, 16'h0);
    check_cfg("R8 port works in standby");
    standby = 0; tick(2);
    chk(power_down === 1'b0, "R8 power_down released", {31'h0, power_down}, 0);

    soft_rst = 1; tick(1); soft_rst = 0; tick(1);
    for (int i = 0; i < 8; i++) model[i] = '0;
    check_cfg("R7 soft reset clears registers");
    single(8'h01, 16'h3333);
    check_cfg("R7 write mode after soft reset");

    for (int k = 0; k < 40; k++) begin
      int nw, tail;
      nw = 1 + ($urandom % 4);
      tail = (($urandom % 4) == 0) ? 1 + ($urandom % 23) : 0;
      cs_open();
      for (int w = 0; w < nw; w++) begin
        logic [7:0] a; logic [15:0] d;
        a = 8'($urandom % 10);
        d = 16'($urandom);
        if (a == 0) d[0] = ($urandom % 3) != 0;
        do_word(a, d);
      end
      if (tail > 0) xfer(24'($urandom), tail, rd, stab, e0);
      cs_close();
      check_cfg("R1 R3 random windows");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule